// File: doc/BRIEF.md
# Dual-Edge Input Capture Timer

This block is a free-running up-counter with an input capture stage that records the counter value when an external signal changes level. Rising and falling transitions each have their own capture register, a sticky event flag and an overrun flag. Each edge type also has its own interrupt enable. The asynchronous capture input is first resynchronised to the block clock. Edge detection then runs on the resynchronised level, so the recorded value is the count on the cycle in which the edge is seen inside the clock domain.

Software reaches the block through a plain register port. The port has a write strobe, a read strobe, an address and a data bus in each direction. Through it software can start and stop the counter, enable the two interrupt sources, read the count and both captured values, and clear flags by writing ones to the status register. A single interrupt line is high while any enabled event flag is set.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: While control bit 0 (run) is 1, the count increases by one per clock and wraps from all ones to zero. While run is 0, the count holds its value.
- R3: `cap_in` passes through SYNC_STAGES flops. If `cap_in` changes just before clock edge k, the capture happens at edge k+SYNC_STAGES and records the count value present just before that edge.
- R4: A rising transition loads the count into the rising capture register (address 3) and leaves the falling capture register unchanged.
- R5: A falling transition loads the count into the falling capture register (address 4) and leaves the rising capture register unchanged.
- R6: A rising capture sets status bit 0. A falling capture sets status bit 1.
- R7: Writing a 1 to a status bit (address 1) clears that bit, and writing a 0 leaves it unchanged. If a capture sets a flag in the same cycle that a write clears it, the flag stays set.
- R8: A capture that occurs while that edge's flag is already set sets an overrun bit: bit 2 for rising, bit 3 for falling. Overrun bits stay set until cleared by writing a 1.
- R9: `irq` is high while (status bit 0 AND control bit 1) OR (status bit 1 AND control bit 2) holds.
- R10: A new capture of the same edge type replaces the stored value, whether or not software has read it.
- R11: Register map: address 0 is control, 1 is status, 2 is count, 3 is rising capture and 4 is falling capture. Other addresses read zero. Writes to addresses 2, 3 and 4 are ignored. Read data appears on `rd_data` in the cycle after `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_in | input | 1 | Asynchronous capture signal |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the timer with CNT_W set to 8 and SYNC_STAGES left at 2. With an 8-bit counter the wrap from 8'hFF to zero happens within a few hundred cycles, so a capture taken after the wrap falls inside a short run. With two synchroniser stages, a capture can be placed so that it lands in the same cycle as a status clear, which exercises the rule that the set wins. All expected captured values come from the cycle at which the counter was started and the cycle at which the input was driven.

// File: rtl/ect_pkg.sv
package ect_pkg;
    // edge indices, also the order of flags within the status word
    localparam int unsigned EDGE_RISE = 0;
    localparam int unsigned EDGE_FALL = 1;
    localparam int unsigned NUM_EDGES = 2;

    // register addresses
    localparam int unsigned REG_CTRL     = 0;
    localparam int unsigned REG_STAT     = 1;
    localparam int unsigned REG_COUNT    = 2;
    localparam int unsigned REG_CAP_BASE = 3;   // rise at +0, fall at +1

    // control word fields
    localparam int unsigned CTRL_RUN     = 0;
    localparam int unsigned CTRL_IE_BASE = 1;   // one enable per edge

    // status word fields
    localparam int unsigned STAT_FLAG_BASE = 0;
    localparam int unsigned STAT_OVR_BASE  = 2;
endpackage

// File: rtl/ect_sync_edge.sv
module ect_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = async_in;
        for (int i = 1; i < int'(STAGES); i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.last = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.chain[STAGES-1];
    assign rise_o  = s_q.chain[STAGES-1] & ~s_q.last;
    assign fall_o  = ~s_q.chain[STAGES-1] & s_q.last;
endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] count_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (run) begin
            s_d.cnt = s_q.cnt + W'(1);   // natural wrap at all ones
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count_o = s_q.cnt;
endmodule

// File: rtl/ect_capture_slot.sv
module ect_capture_slot #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  logic [W-1:0] count_i,
    input  logic         clr_flag,
    input  logic         clr_ovr,
    output logic [W-1:0] value_o,
    output logic         flag_o,
    output logic         ovr_o
);
    typedef struct packed {
        logic [W-1:0] value;
        logic         flag;
        logic         ovr;
    } slot_st_t;

    slot_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_flag) begin
            s_d.flag = 1'b0;
        end
        if (clr_ovr) begin
            s_d.ovr = 1'b0;
        end
        // a capture overrides any clear in the same cycle
        if (hit) begin
            s_d.value = count_i;
            s_d.flag  = 1'b1;
            if (s_q.flag) begin
                s_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign value_o = s_q.value;
    assign flag_o  = s_q.flag;
    assign ovr_o   = s_q.ovr;
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
    import ect_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    localparam int unsigned REG_CAP_RISE = REG_CAP_BASE + EDGE_RISE;
    localparam int unsigned REG_CAP_FALL = REG_CAP_BASE + EDGE_FALL;

    typedef struct packed {
        logic                 run;
        logic [NUM_EDGES-1:0] ie;
        logic [CNT_W-1:0]     rd_data;
    } top_st_t;

    top_st_t s_d, s_q;

    logic                 sync_level;
    logic [NUM_EDGES-1:0] edge_hit;
    logic [CNT_W-1:0]     count;
    logic [CNT_W-1:0]     cap_val [NUM_EDGES];
    logic [NUM_EDGES-1:0] flag;
    logic [NUM_EDGES-1:0] ovr;
    logic [NUM_EDGES-1:0] clr_flag;
    logic [NUM_EDGES-1:0] clr_ovr;
    logic                 ctrl_wr;
    logic                 stat_wr;
    logic [CNT_W-1:0]     rd_next;

    ect_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cap_in),
        .level_o  (sync_level),
        .rise_o   (edge_hit[EDGE_RISE]),
        .fall_o   (edge_hit[EDGE_FALL])
    );

    ect_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.run),
        .count_o (count)
    );

    assign ctrl_wr = wr_en && (int'(addr) == int'(REG_CTRL));
    assign stat_wr = wr_en && (int'(addr) == int'(REG_STAT));

    for (genvar e = 0; e < int'(NUM_EDGES); e++) begin : g_slot
        assign clr_flag[e] = stat_wr && wr_data[STAT_FLAG_BASE + e];
        assign clr_ovr[e]  = stat_wr && wr_data[STAT_OVR_BASE + e];

        ect_capture_slot #(.W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (edge_hit[e]),
            .count_i  (count),
            .clr_flag (clr_flag[e]),
            .clr_ovr  (clr_ovr[e]),
            .value_o  (cap_val[e]),
            .flag_o   (flag[e]),
            .ovr_o    (ovr[e])
        );
    end

    // read multiplexer
    always_comb begin
        rd_next = '0;
        case (int'(addr))
            int'(REG_CTRL): begin
                rd_next[CTRL_RUN]                   = s_q.run;
                rd_next[CTRL_IE_BASE +: NUM_EDGES]  = s_q.ie;
            end
            int'(REG_STAT): begin
                rd_next[STAT_FLAG_BASE +: NUM_EDGES] = flag;
                rd_next[STAT_OVR_BASE +: NUM_EDGES]  = ovr;
            end
            int'(REG_COUNT):    rd_next = count;
            int'(REG_CAP_RISE): rd_next = cap_val[EDGE_RISE];
            int'(REG_CAP_FALL): rd_next = cap_val[EDGE_FALL];
            default:            rd_next = '0;
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (ctrl_wr) begin
            s_d.run = wr_data[CTRL_RUN];
            s_d.ie  = wr_data[CTRL_IE_BASE +: NUM_EDGES];
        end
        if (rd_en) begin
            s_d.rd_data = rd_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.rd_data;
    assign irq     = |(flag & s_q.ie);
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic [1:0]   ie,
    input logic [1:0]   hit,
    input logic [1:0]   flag,
    input logic [1:0]   ovr,
    input logic [W-1:0] count,
    input logic [W-1:0] cap_rise,
    input logic [W-1:0] cap_fall,
    input logic         stat_wr,
    input logic [W-1:0] wr_data,
    input logic         irq
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> count == $past(count) + W'(1));                          // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count));                                        // R2
    AST_RISE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> cap_rise == $past(count));                            // R3
    AST_RISE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !hit[0] |=> $stable(cap_rise));                                  // R4
    AST_FALL_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |=> cap_fall == $past(count));                            // R5
    AST_FALL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !hit[1] |=> $stable(cap_fall));                                  // R5
    AST_RISE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> flag[0]);                                             // R6
    AST_FALL_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |=> flag[1]);                                             // R6
    AST_RISE_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && wr_data[0] && !hit[0] |=> !flag[0]);                  // R7
    AST_FALL_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] && flag[1] |=> ovr[1]);                                   // R8
    AST_RISE_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ovr[0] && !(stat_wr && wr_data[2]) |=> ovr[0]);                  // R8
    AST_RISE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] && ie[0] |=> irq);                                        // R9
endmodule

bind edge_capture_timer ect_checker #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (s_q.run),
    .ie       (s_q.ie),
    .hit      (edge_hit),
    .flag     (flag),
    .ovr      (ovr),
    .count    (count),
    .cap_rise (cap_val[0]),
    .cap_fall (cap_val[1]),
    .stat_wr  (stat_wr),
    .wr_data  (wr_data),
    .irq      (irq)
);

// File: tb/edge_capture_timer_test.sv
module edge_capture_timer_test;
    localparam int TW   = 8;
    localparam int AW   = 3;
    localparam int SS   = 2;
    localparam int MASK = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_in = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [TW-1:0] wr_data = '0;
    logic [TW-1:0] rd_data;
    logic          irq;

    edge_capture_timer #(.CNT_W(TW), .ADDR_W(AW), .SYNC_STAGES(SS)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_in  (cap_in),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        int    exp;
        string tag;
    } item_t;
    item_t sb[$];

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: a read strobe seen at an edge yields data readable after it
    logic rd_was = 1'b0;
    always @(posedge clk) rd_was <= rd_en;
    always @(negedge clk) begin
        if (rd_was) begin
            if (sb.size() == 0) begin
                check("SB_EMPTY", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, int'(rd_data), it.exp);
            end
        end
    end

    task automatic wr(input int a, input int d, output int w);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wr_data = TW'(d); w = cyc;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        item_t it;
        @(negedge clk);
        it.exp = exp & MASK; it.tag = tag;
        sb.push_back(it);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    int wrun = 0;

    // the count after edge n is n - (wrun + 1) while running
    task automatic rd_count(input string tag);
        item_t it;
        @(negedge clk);
        it.exp = (cyc - wrun - 1) & MASK; it.tag = tag;
        sb.push_back(it);
        rd_en = 1'b1; addr = AW'(2);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic cap(input logic lvl, output int c);
        @(negedge clk);
        cap_in = lvl; c = cyc;
    endtask

    function automatic int cap_exp(int c);
        return (c + SS - 1 - wrun) & MASK;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    int w, c1, c2, c3, c4, c5, c6, c7, wstop, frozen;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", int'(irq), 0);
        rd(0, 0, "R1 ctrl reset");
        rd(1, 0, "R1 status reset");
        rd(2, 0, "R1 count reset");
        rd(3, 0, "R1 rise capture reset");
        rd(4, 0, "R1 fall capture reset");

        // start counting, rising interrupt enabled
        wr(0, 'h3, wrun);
        rd(0, 'h3, "R11 ctrl readback");
        wr(2, 'h55, w);
        rd_count("R11 count write ignored / R2 running");

        cap(1'b1, c1);
        idle(5);
        rd(3, cap_exp(c1), "R3 R4 rise capture value");
        rd(4, 0, "R4 fall capture untouched");
        rd(1, 'h1, "R6 rise flag");
        check("R9 irq on enabled rise flag", int'(irq), 1);
        wr(3, 'hAA, w);
        rd(3, cap_exp(c1), "R11 capture write ignored");

        cap(1'b0, c2);
        idle(5);
        rd(4, cap_exp(c2), "R5 fall capture value");
        rd(3, cap_exp(c1), "R5 rise capture untouched");
        rd(1, 'h3, "R6 both flags");

        wr(1, 'h0, w);
        rd(1, 'h3, "R7 write zero keeps flags");
        wr(1, 'h1, w);
        rd(1, 'h2, "R7 clear rise flag");
        check("R9 irq low with fall flag disabled", int'(irq), 0);

        cap(1'b1, c3);
        idle(5);
        cap(1'b0, c4);
        idle(5);
        rd(1, 'hB, "R8 fall overrun");
        rd(4, cap_exp(c4), "R10 fall capture overwritten");
        check("R9 irq from new rise flag", int'(irq), 1);

        // capture lands in the same edge as the clear of the rise flag
        cap(1'b1, c5);
        @(negedge clk);
        wr(1, 'h1, w);
        rd(1, 'hF, "R7 set wins over clear / R8 rise overrun");
        rd(3, cap_exp(c5), "R10 rise capture overwritten");

        wr(1, 'hF, w);
        rd(1, 'h0, "R7 clear all");
        check("R9 irq low after clear", int'(irq), 0);
        wr(0, 'h5, w);
        cap(1'b0, c6);
        idle(5);
        check("R9 irq on enabled fall flag", int'(irq), 1);
        rd(1, 'h2, "R6 fall flag only");

        idle(300);
        rd_count("R2 count after wrap");
        cap(1'b1, c7);
        idle(5);
        rd(3, cap_exp(c7), "R3 capture after wrap");

        wr(0, 'h0, wstop);
        frozen = wstop - wrun;
        check("R9 irq low with enables off", int'(irq), 0);
        idle(4);
        rd(2, frozen, "R2 count stopped");
        idle(3);
        rd(2, frozen, "R2 count holds");
        rd(7, 0, "R11 unused address");

        idle(3);
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule